// File: doc/BRIEF.md
# Dual-Layer Data Crossbar Selector

This block is the data-side switch of a five-port circuit-switched router that carries traffic on one of two data layers. Both layers use the same per-output select codes, which come from the router's control unit. The first layer is the high-speed layer. It registers every forwarded word and every returned acknowledgment, so each one appears one cycle later. The second layer is the low-power handshake layer. It routes words and acknowledgments straight through with no clock stage. Each output port takes a data word, its activation bit and its request from the input its select code names. Each acknowledgment travels the other way, from an output back to the input that feeds it.

Only one layer is powered at a time. A small controller holds the active layer and drives one enable per layer. These enables stand in for the power switches. A disabled layer clears its registers and clamps its outputs to zero, which models the isolation cells. The same layer state drives the final multiplexer that chooses which layer's results leave the router. A request to change layer is taken only while no output port is reserved. While a path is reserved, the request waits and takes effect on the clock edge at which the reservation clears.

The controller has four states: FAST_IDLE, FAST_BUSY, LP_IDLE and LP_BUSY. Its transitions are:

| From | Condition | To |
|------|-----------|----|
| FAST_IDLE | any output reserved | FAST_BUSY |
| FAST_IDLE | no output reserved, low-power layer requested | LP_IDLE |
| FAST_BUSY | reservations cleared, low-power layer requested | LP_IDLE |
| FAST_BUSY | reservations cleared, high-speed layer requested | FAST_IDLE |
| LP_IDLE | any output reserved | LP_BUSY |
| LP_IDLE | no output reserved, high-speed layer requested | FAST_IDLE |
| LP_BUSY | reservations cleared, high-speed layer requested | FAST_IDLE |
| LP_BUSY | reservations cleared, low-power layer requested | LP_IDLE |

Top module: `dlx_xbar`

## Requirements
- R1: After reset the block is in FAST_IDLE. layer_o is 0, fast_en_o is 1 and lp_en_o is 0. Every output data word, activation bit, request and input acknowledgment is 0.
- R2: Output port o is live when path_rsv_i[o] is 1, its 3-bit select code (bits [3o+2:3o] of sel_i) holds an input index from 0 to 4, and that input's activation bit is 1. A live output carries the selected input's 32-bit word (bits [32i+31:32i]), its activation bit set to 1, and its request.
- R3: in_ack_o[i] is the OR of out_ack_i[o] over every live output o whose select code names input i. This includes the case where two outputs select the same input.
- R4: An output whose select code is 5, 6 or 7, or whose reservation bit is 0, drives data, activation and request as 0. It adds nothing to any acknowledgment.
- R5: An output whose selected input has activation bit 0 forwards no data, activation or request, and returns no acknowledgment.
- R6: On the high-speed layer (layer_o = 0), forwarded outputs and returned acknowledgments appear one clock edge after their inputs.
- R7: On the low-power layer (layer_o = 1), forwarded outputs and returned acknowledgments follow their inputs in the same cycle, with no clock edge between them.
- R8: Exactly one of fast_en_o and lp_en_o is 1 in every cycle. lp_en_o equals layer_o.
- R9: When no output is reserved and layer_req_i differs from layer_o, layer_o takes the value of layer_req_i at the next clock edge.
- R10: While any output is reserved, layer_o does not change at the next edge. A pending change takes effect at the edge where all reservation bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| layer_req_i | input | 1 | Requested layer: 0 high-speed, 1 low-power |
| path_rsv_i | input | 5 | Per-output reservation from the control unit |
| sel_i | input | 15 | Per-output 3-bit input select code |
| in_data_i | input | 160 | Five 32-bit input words |
| in_act_i | input | 5 | Per-input activation bit |
| in_req_i | input | 5 | Per-input request |
| in_ack_o | output | 5 | Per-input acknowledgment returned upstream |
| out_data_o | output | 160 | Five 32-bit output words |
| out_act_o | output | 5 | Per-output activation bit for the next router |
| out_req_o | output | 5 | Per-output request |
| out_ack_i | input | 5 | Per-output acknowledgment from downstream |
| layer_o | output | 1 | Active layer |
| fast_en_o | output | 1 | High-speed layer enable |
| lp_en_o | output | 1 | Low-power layer enable |

## Verification
Some properties are checked on every cycle: exactly one layer enable is high, the layer stays put while a reservation is held, a layer change lands on the first edge with no reservation, and an unreserved or invalidly selected output on the low-power layer never raises a request. Other behaviour can only be shown by the directed scenarios. These cover the actual words routed for particular select patterns, the backward acknowledgment mapping including two outputs sharing one input, gating by the activation bit, and the difference in latency between the two layers, sampled before and after an edge.

// File: rtl/dlx_pkg.sv
package dlx_pkg;

    typedef enum logic [1:0] {
        ST_FAST_IDLE = 2'd0,
        ST_FAST_BUSY = 2'd1,
        ST_LP_IDLE   = 2'd2,
        ST_LP_BUSY   = 2'd3
    } dlx_state_t;

    localparam logic LAYER_FAST = 1'b0;
    localparam logic LAYER_LP   = 1'b1;

    function automatic logic layer_of(input dlx_state_t st);
        return (st == ST_LP_IDLE) || (st == ST_LP_BUSY);
    endfunction

endpackage

// File: rtl/dlx_route.sv
module dlx_route #(
    parameter int NPORT = 5,
    parameter int DW    = 32,
    parameter int SELW  = 3
) (
    input  logic                  en,
    input  logic [NPORT*DW-1:0]   in_data,
    input  logic [NPORT-1:0]      in_act,
    input  logic [NPORT-1:0]      in_req,
    input  logic [NPORT*SELW-1:0] sel,
    input  logic [NPORT-1:0]      rsv,
    input  logic [NPORT-1:0]      out_ack,
    output logic [NPORT*DW-1:0]   o_data,
    output logic [NPORT-1:0]      o_act,
    output logic [NPORT-1:0]      o_req,
    output logic [NPORT-1:0]      i_ack
);

    // Forward selection and backward acknowledgment share one match test.
    always_comb begin
        o_data = '0;
        o_act  = '0;
        o_req  = '0;
        i_ack  = '0;
        for (int o = 0; o < NPORT; o++) begin
            for (int i = 0; i < NPORT; i++) begin
                if (en && rsv[o] && in_act[i] &&
                    (sel[o*SELW +: SELW] == SELW'(i))) begin
                    o_data[o*DW +: DW] = in_data[i*DW +: DW];
                    o_act[o]           = 1'b1;
                    o_req[o]           = in_req[i];
                    i_ack[i]           = i_ack[i] | out_ack[o];
                end
            end
        end
    end

endmodule

// File: rtl/dlx_fast_stage.sv
module dlx_fast_stage #(
    parameter int NPORT = 5,
    parameter int DW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [NPORT*DW-1:0] d_data,
    input  logic [NPORT-1:0]    d_act,
    input  logic [NPORT-1:0]    d_req,
    input  logic [NPORT-1:0]    d_ack,
    output logic [NPORT*DW-1:0] q_data,
    output logic [NPORT-1:0]    q_act,
    output logic [NPORT-1:0]    q_req,
    output logic [NPORT-1:0]    q_ack
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_data <= '0;
            q_act  <= '0;
            q_req  <= '0;
            q_ack  <= '0;
        end else if (en) begin
            q_data <= d_data;
            q_act  <= d_act;
            q_req  <= d_req;
            q_ack  <= d_ack;
        end else begin
            q_data <= '0;
            q_act  <= '0;
            q_req  <= '0;
            q_ack  <= '0;
        end
    end

endmodule

// File: rtl/dlx_layer_fsm.sv
module dlx_layer_fsm
    import dlx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic layer_req_i,
    input  logic busy_i,
    output logic layer_o,
    output logic fast_en_o,
    output logic lp_en_o
);

    dlx_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FAST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FAST_IDLE: begin
                if (busy_i)                        state_d = ST_FAST_BUSY;
                else if (layer_req_i == LAYER_LP)  state_d = ST_LP_IDLE;
            end
            ST_FAST_BUSY: begin
                if (!busy_i) state_d = (layer_req_i == LAYER_LP) ? ST_LP_IDLE : ST_FAST_IDLE;
            end
            ST_LP_IDLE: begin
                if (busy_i)                         state_d = ST_LP_BUSY;
                else if (layer_req_i == LAYER_FAST) state_d = ST_FAST_IDLE;
            end
            ST_LP_BUSY: begin
                if (!busy_i) state_d = (layer_req_i == LAYER_FAST) ? ST_FAST_IDLE : ST_LP_IDLE;
            end
            default: state_d = ST_FAST_IDLE;
        endcase
    end

    always_comb begin
        layer_o   = layer_of(state_q);
        lp_en_o   = layer_o;
        fast_en_o = ~layer_o;
    end

endmodule

// File: rtl/dlx_xbar.sv
module dlx_xbar #(
    parameter int NPORT = 5,
    parameter int DW    = 32,
    parameter int SELW  = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  layer_req_i,
    input  logic [NPORT-1:0]      path_rsv_i,
    input  logic [NPORT*SELW-1:0] sel_i,
    input  logic [NPORT*DW-1:0]   in_data_i,
    input  logic [NPORT-1:0]      in_act_i,
    input  logic [NPORT-1:0]      in_req_i,
    output logic [NPORT-1:0]      in_ack_o,
    output logic [NPORT*DW-1:0]   out_data_o,
    output logic [NPORT-1:0]      out_act_o,
    output logic [NPORT-1:0]      out_req_o,
    input  logic [NPORT-1:0]      out_ack_i,
    output logic                  layer_o,
    output logic                  fast_en_o,
    output logic                  lp_en_o
);

    localparam int NLAYER = 2;

    logic [NLAYER-1:0]   lay_en;
    logic [NPORT*DW-1:0] rt_data [NLAYER];
    logic [NPORT-1:0]    rt_act  [NLAYER];
    logic [NPORT-1:0]    rt_req  [NLAYER];
    logic [NPORT-1:0]    rt_ack  [NLAYER];

    logic [NPORT*DW-1:0] fs_data;
    logic [NPORT-1:0]    fs_act, fs_req, fs_ack;

    dlx_layer_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .layer_req_i (layer_req_i),
        .busy_i      (|path_rsv_i),
        .layer_o     (layer_o),
        .fast_en_o   (fast_en_o),
        .lp_en_o     (lp_en_o)
    );

    assign lay_en = {lp_en_o, fast_en_o};

    for (genvar g = 0; g < NLAYER; g++) begin : g_layer
        dlx_route #(.NPORT(NPORT), .DW(DW), .SELW(SELW)) u_route (
            .en      (lay_en[g]),
            .in_data (in_data_i),
            .in_act  (in_act_i),
            .in_req  (in_req_i),
            .sel     (sel_i),
            .rsv     (path_rsv_i),
            .out_ack (out_ack_i),
            .o_data  (rt_data[g]),
            .o_act   (rt_act[g]),
            .o_req   (rt_req[g]),
            .i_ack   (rt_ack[g])
        );
    end

    dlx_fast_stage #(.NPORT(NPORT), .DW(DW)) u_fast (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (fast_en_o),
        .d_data (rt_data[0]),
        .d_act  (rt_act[0]),
        .d_req  (rt_req[0]),
        .d_ack  (rt_ack[0]),
        .q_data (fs_data),
        .q_act  (fs_act),
        .q_req  (fs_req),
        .q_ack  (fs_ack)
    );

    // Final layer multiplexer plus isolation clamp on the inactive layer.
    always_comb begin
        if (lp_en_o) begin
            out_data_o = rt_data[1];
            out_act_o  = rt_act[1];
            out_req_o  = rt_req[1];
            in_ack_o   = rt_ack[1];
        end else begin
            out_data_o = fs_data;
            out_act_o  = fs_act;
            out_req_o  = fs_req;
            in_ack_o   = fs_ack;
        end
    end

endmodule

// File: rtl/dlx_xbar_chk.sv
module dlx_xbar_chk #(
    parameter int NPORT = 5,
    parameter int SELW  = 3
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  layer_req_i,
    input logic [NPORT-1:0]      path_rsv_i,
    input logic [NPORT*SELW-1:0] sel_i,
    input logic [NPORT-1:0]      out_req_o,
    input logic                  layer_o,
    input logic                  fast_en_o,
    input logic                  lp_en_o
);

    assert_one_layer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({fast_en_o, lp_en_o}) == 1) && (lp_en_o == layer_o));

    assert_switch_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((path_rsv_i == '0) && (layer_req_i != layer_o)) |=> (layer_o == $past(layer_req_i)));

    assert_hold_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (path_rsv_i != '0) |=> $stable(layer_o));

    for (genvar o = 0; o < NPORT; o++) begin : g_port
        assert_dead_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (lp_en_o && (!path_rsv_i[o] || (sel_i[o*SELW +: SELW] >= SELW'(NPORT))))
            |-> !out_req_o[o]);
    end

endmodule

bind dlx_xbar dlx_xbar_chk #(.NPORT(NPORT), .SELW(SELW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .layer_req_i (layer_req_i),
    .path_rsv_i  (path_rsv_i),
    .sel_i       (sel_i),
    .out_req_o   (out_req_o),
    .layer_o     (layer_o),
    .fast_en_o   (fast_en_o),
    .lp_en_o     (lp_en_o)
);

// File: tb/sim_dlx_xbar.sv
`timescale 1ns/100ps
module sim_dlx_xbar;

    localparam int NP = 5;
    localparam int DW = 32;
    localparam int SW = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              layer_req = 1'b0;
    logic [NP-1:0]     rsv = '0;
    logic [NP*SW-1:0]  sel = '0;
    logic [NP*DW-1:0]  din = '0;
    logic [NP-1:0]     act = '0;
    logic [NP-1:0]     req = '0;
    logic [NP-1:0]     oack = '0;
    logic [NP-1:0]     iack;
    logic [NP*DW-1:0]  dout;
    logic [NP-1:0]     oact, oreq;
    logic              layer, fen, len;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dlx_xbar u0 (
        .clk(clk), .rst_n(rst_n), .layer_req_i(layer_req), .path_rsv_i(rsv),
        .sel_i(sel), .in_data_i(din), .in_act_i(act), .in_req_i(req),
        .in_ack_o(iack), .out_data_o(dout), .out_act_o(oact), .out_req_o(oreq),
        .out_ack_i(oack), .layer_o(layer), .fast_en_o(fen), .lp_en_o(len)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] a, input logic [63:0] e);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    // Reference routing from the requirement text.
    task automatic expect_all(input string tag);
        logic [NP*DW-1:0] ed;
        logic [NP-1:0] ea, er, ek;
        ed = '0; ea = '0; er = '0; ek = '0;
        for (int o = 0; o < NP; o++) begin
            int s;
            s = int'(sel[o*SW +: SW]);
            if (rsv[o] && s < NP && act[s]) begin
                ed[o*DW +: DW] = din[s*DW +: DW];
                ea[o] = 1'b1;
                er[o] = req[s];
                if (oack[o]) ek[s] = 1'b1;
            end
        end
        for (int o = 0; o < NP; o++)
            chk(dout[o*DW +: DW] == ed[o*DW +: DW], {tag, " data"},
                64'(dout[o*DW +: DW]), 64'(ed[o*DW +: DW]));
        chk(oact == ea, {tag, " act"}, 64'(oact), 64'(ea));
        chk(oreq == er, {tag, " req"}, 64'(oreq), 64'(er));
        chk(iack == ek, {tag, " ack"}, 64'(iack), 64'(ek));
    endtask

    task automatic expect_quiet(input string tag);
        chk(dout == '0, {tag, " data zero"}, 64'(dout[63:0]), 64'd0);
        chk(oact == '0 && oreq == '0 && iack == '0, {tag, " ctl zero"},
            64'({oact, oreq, iack}), 64'd0);
    endtask

    task automatic load_words(input logic [31:0] base);
        for (int i = 0; i < NP; i++) din[i*DW +: DW] = base + 32'(i) * 32'h0101_0111;
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5;
        chk(layer == 1'b0 && fen && !len, "R1 layer state", 64'({layer, fen, len}), 64'b010);
        expect_quiet("R1 outputs");
    endtask

    task automatic t_fast_route;
        @(negedge clk);
        load_words(32'hA000_0000);
        act = '1; req = 5'b10110; oack = 5'b00101; rsv = '1;
        for (int o = 0; o < NP; o++) sel[o*SW +: SW] = SW'((o + 1) % NP);
        #0.5;
        expect_quiet("R6 before edge");
        @(posedge clk); #0.5;
        expect_all("R2 R3 R6 fast after edge");
        chk(layer == 1'b0, "R8 still fast", 64'(layer), 64'd0);
    endtask

    task automatic t_dead_ports;
        @(negedge clk);
        sel[0*SW +: SW] = 3'd7;
        sel[1*SW +: SW] = 3'd5;
        sel[2*SW +: SW] = 3'd6;
        rsv = 5'b10101;
        oack = '1;
        @(posedge clk); #0.5;
        expect_all("R4 dead ports");
        chk(oreq[2:0] == 3'b000, "R4 no req", 64'(oreq[2:0]), 64'd0);
    endtask

    task automatic t_act_gate;
        @(negedge clk);
        rsv = '1; oack = '1; req = '1;
        for (int o = 0; o < NP; o++) sel[o*SW +: SW] = SW'(o);
        act = 5'b11011;
        @(posedge clk); #0.5;
        expect_all("R5 activation gate");
        chk(dout[2*DW +: DW] == '0 && !iack[2], "R5 port2 blocked",
            64'({iack[2], dout[2*DW +: DW]}), 64'd0);
    endtask

    task automatic t_switch_held;
        @(negedge clk);
        act = '1; rsv = 5'b01000; layer_req = 1'b1;
        repeat (3) @(posedge clk);
        #0.5;
        chk(layer == 1'b0 && fen, "R10 held while reserved", 64'(layer), 64'd0);
        @(negedge clk) rsv = '0;
        #0.5;
        chk(layer == 1'b0, "R10 not before edge", 64'(layer), 64'd0);
        @(posedge clk); #0.5;
        chk(layer == 1'b1 && len && !fen, "R9 R10 switch on release",
            64'({layer, fen, len}), 64'b101);
    endtask

    task automatic t_lp_route;
        @(negedge clk);
        load_words(32'h5C00_0003);
        act = '1; req = 5'b01101; oack = 5'b11010; rsv = 5'b11011;
        for (int o = 0; o < NP; o++) sel[o*SW +: SW] = SW'((o + 2) % NP);
        #0.5;
        expect_all("R7 lp same cycle");
        chk(layer == 1'b1, "R10 lp held", 64'(layer), 64'd1);
    endtask

    task automatic t_lp_shared;
        @(negedge clk);
        rsv = '1; act = '1;
        for (int o = 0; o < NP; o++) sel[o*SW +: SW] = 3'd7;
        sel[0*SW +: SW] = 3'd3;
        sel[1*SW +: SW] = 3'd3;
        oack = 5'b00010;
        #0.5;
        chk(iack == 5'b01000, "R3 shared input ack", 64'(iack), 64'h08);
        chk(dout[0*DW +: DW] == din[3*DW +: DW] && dout[1*DW +: DW] == din[3*DW +: DW],
            "R2 fan-out", 64'(dout[DW +: DW]), 64'(din[3*DW +: DW]));
        oack = 5'b00000;
        #0.5;
        chk(iack == 5'b00000, "R3 ack drop same cycle", 64'(iack), 64'd0);
    endtask

    task automatic t_switch_back;
        @(negedge clk);
        rsv = '0; layer_req = 1'b0;
        #0.5;
        expect_quiet("R4 lp unreserved");
        @(posedge clk); #0.5;
        chk(layer == 1'b0 && fen && !len, "R9 back to fast", 64'({layer, fen, len}), 64'b010);
        expect_quiet("R6 fast clean after switch");
    endtask

    initial begin
        t_reset();
        t_fast_route();
        t_dead_ports();
        t_act_gate();
        t_switch_held();
        t_lp_route();
        t_lp_shared();
        t_switch_back();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule